// File: doc/BRIEF.md
# Shaped On-Off Keying Amplitude Ramp

This block generates the 14-bit amplitude scale factor that a synthesizer applies to its output samples. Bursts can then fade in and fade out along linear ramps instead of switching abruptly. The scale configuration and the ramp-rate value are loaded into shadow registers on an update strobe. Between strobes, the values on the configuration inputs have no effect.

The block has three operating states:

- **Disabled.** Keying is off and the output sits at full scale.
- **Manual.** The lower 14 bits of the loaded scale configuration go straight to the output.
- **Auto.** A ramp counter moves toward the loaded ceiling while the keying pin is high, and toward zero while it is low. The counter moves by a step set by a 2-bit code, once every (rate + 1) clocks.

Top module: `osk_ramp_top`

## Requirements
- R1: After reset, with keying disabled, `scale_o` is 0x3FFF, and both shadow registers hold zero.
- R2: `cfg_scale_i` and `cfg_rate_i` are copied into the shadow registers only in a cycle where `upd_i` is high. Changes on those inputs at any other time leave `scale_o` unchanged.
- R3: While `osk_en_i` is low, `scale_o` is 0x3FFF, whatever the configuration or the keying pin holds.
- R4: While `osk_en_i` is high and `osk_auto_i` is low, `scale_o` equals bits [13:0] of the loaded scale configuration. Bits [15:14] have no effect.
- R5: In auto mode with `key_i` high, each ramp update adds the step to the counter, and `scale_o` shows the counter.
- R6: The step comes from bits [15:14] of the loaded configuration: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R7: Ramp updates happen once every (loaded rate + 1) clocks. A rate of 0 gives an update on every clock.
- R8: Ramping up saturates at the ceiling in bits [13:0] of the loaded configuration, with no overshoot. A counter above the ceiling is brought down to the ceiling on the next up-update.
- R9: In auto mode with `key_i` low, each update subtracts the step, and the counter saturates at zero.
- R10: Outside auto mode, the counter and the rate divider are held at zero. After auto mode is entered, the first update comes on the (rate + 1)-th clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_i | input | 1 | Update strobe that loads the configuration inputs |
| cfg_scale_i | input | 16 | Step code in [15:14], scale value or ceiling in [13:0] |
| cfg_rate_i | input | 8 | Ramp-rate divider value |
| osk_en_i | input | 1 | Keying enable |
| osk_auto_i | input | 1 | 1 selects auto ramp, 0 selects manual |
| key_i | input | 1 | Keying pin: high ramps up, low ramps down |
| scale_o | output | 14 | Amplitude scale factor |

## Verification
The assertions treat the enable, mode and keying inputs as synchronous levels that are stable around each clock edge. The bench meets this by driving every input on the falling edge. The ceiling and step properties compare against the configuration that was loaded before the edge. Reloads are therefore allowed at any time, including in the middle of a ramp, and the random phase uses them that way, so ceilings can drop below a counter that is already running. The random stimulus covers every step code, rates from 0 to 5, and mode changes between disabled, manual and auto.

// File: rtl/osk_pkg.sv
package osk_pkg;
    typedef enum logic [1:0] {
        SRC_FULL   = 2'd0,
        SRC_MANUAL = 2'd1,
        SRC_RAMP   = 2'd2
    } scale_src_e;
endpackage

// File: rtl/osk_shadow.sv
module osk_shadow #(
    parameter int unsigned CFG_W  = 16,
    parameter int unsigned RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [CFG_W-1:0]  scale_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic [CFG_W-1:0]  scale_o,
    output logic [RATE_W-1:0] rate_o
);
    typedef struct packed {
        logic [CFG_W-1:0]  scale;
        logic [RATE_W-1:0] rate;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_i) begin
            st_d.scale = scale_i;
            st_d.rate  = rate_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scale_o = st_q.scale;
    assign rate_o  = st_q.rate;
endmodule

// File: rtl/osk_rate_div.sv
module osk_rate_div #(
    parameter int unsigned RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [RATE_W-1:0] cnt;
    } div_t;

    div_t st_d, st_q;
    logic wrap;

    always_comb begin
        st_d = st_q;
        wrap = st_q.cnt >= rate_i;
        if (!run_i)    st_d.cnt = '0;
        else if (wrap) st_d.cnt = '0;
        else           st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = run_i && wrap;
endmodule

// File: rtl/osk_ramp_ctr.sv
module osk_ramp_ctr #(
    parameter int unsigned AMP_W = 14,
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             key_i,
    input  logic [AMP_W-1:0] ceil_i,
    input  logic [SEL_W-1:0] code_i,
    output logic [AMP_W-1:0] level_o
);
    localparam int unsigned SUM_W = AMP_W + 1;

    typedef struct packed {
        logic [AMP_W-1:0] level;
    } ramp_t;

    ramp_t st_d, st_q;
    logic [SUM_W-1:0] step;
    logic [SUM_W-1:0] sum_up;

    always_comb begin
        st_d   = st_q;
        step   = SUM_W'(1) << code_i;
        sum_up = {1'b0, st_q.level} + step;
        if (!run_i) begin
            st_d.level = '0;
        end else if (tick_i) begin
            if (key_i) begin
                if (sum_up >= {1'b0, ceil_i}) st_d.level = ceil_i;
                else                          st_d.level = sum_up[AMP_W-1:0];
            end else begin
                if ({1'b0, st_q.level} <= step) st_d.level = '0;
                else st_d.level = st_q.level - step[AMP_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;
endmodule

// File: rtl/osk_ramp_top.sv
module osk_ramp_top #(
    parameter int unsigned AMP_W  = 14,
    parameter int unsigned SEL_W  = 2,
    parameter int unsigned RATE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd_i,
    input  logic [AMP_W+SEL_W-1:0] cfg_scale_i,
    input  logic [RATE_W-1:0]      cfg_rate_i,
    input  logic                   osk_en_i,
    input  logic                   osk_auto_i,
    input  logic                   key_i,
    output logic [AMP_W-1:0]       scale_o
);
    import osk_pkg::*;
    localparam int unsigned CFG_W = AMP_W + SEL_W;

    logic [CFG_W-1:0]  asf_q;
    logic [RATE_W-1:0] arr_q;
    logic              act;
    logic              tick;
    logic [AMP_W-1:0]  ctr;
    scale_src_e        src;

    assign act = osk_en_i && osk_auto_i;

    osk_shadow #(.CFG_W(CFG_W), .RATE_W(RATE_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .upd_i(upd_i),
        .scale_i(cfg_scale_i), .rate_i(cfg_rate_i),
        .scale_o(asf_q), .rate_o(arr_q)
    );

    osk_rate_div #(.RATE_W(RATE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run_i(act),
        .rate_i(arr_q), .tick_o(tick)
    );

    osk_ramp_ctr #(.AMP_W(AMP_W), .SEL_W(SEL_W)) u_ramp (
        .clk(clk), .rst_n(rst_n), .run_i(act), .tick_i(tick),
        .key_i(key_i), .ceil_i(asf_q[AMP_W-1:0]),
        .code_i(asf_q[CFG_W-1:AMP_W]), .level_o(ctr)
    );

    always_comb begin
        if (!osk_en_i)        src = SRC_FULL;
        else if (!osk_auto_i) src = SRC_MANUAL;
        else                  src = SRC_RAMP;
        case (src)
            SRC_MANUAL: scale_o = asf_q[AMP_W-1:0];
            SRC_RAMP:   scale_o = ctr;
            default:    scale_o = '1;
        endcase
    end
endmodule

// File: rtl/osk_ramp_chk.sv
module osk_ramp_chk #(
    parameter int unsigned AMP_W  = 14,
    parameter int unsigned RATE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd,
    input logic              en,
    input logic              act,
    input logic              key,
    input logic              tick,
    input logic [AMP_W-1:0]  ceil,
    input logic [RATE_W-1:0] rate,
    input logic [AMP_W-1:0]  ctr,
    input logic [AMP_W-1:0]  scale
);
    AST_DISABLED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> scale == '1); // R3
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(ceil) && $stable(rate)); // R2
    AST_UP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (act && tick && key && ctr <= ceil) |=> ctr >= $past(ctr)); // R5
    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (act && tick && key) |=> ctr <= $past(ceil)); // R8
    AST_DOWN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (act && tick && !key) |=> ctr <= $past(ctr)); // R9
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !tick) |=> $stable(ctr)); // R7
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> ctr == '0); // R10
endmodule

bind osk_ramp_top osk_ramp_chk #(.AMP_W(AMP_W), .RATE_W(RATE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .upd(upd_i), .en(osk_en_i), .act(act),
    .key(key_i), .tick(tick), .ceil(asf_q[AMP_W-1:0]), .rate(arr_q),
    .ctr(ctr), .scale(scale_o)
);

// File: tb/osk_ramp_top_test.sv
module osk_ramp_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_i = 1'b0;
    logic [15:0] cfg_scale_i = '0;
    logic [7:0]  cfg_rate_i = '0;
    logic        osk_en_i = 1'b0;
    logic        osk_auto_i = 1'b0;
    logic        key_i = 1'b0;
    logic [13:0] scale_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_asf = 0, m_arr = 0, m_cnt = 0, m_ctr = 0;

    always #5 clk = ~clk;

    osk_ramp_top uut (
        .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .cfg_scale_i(cfg_scale_i),
        .cfg_rate_i(cfg_rate_i), .osk_en_i(osk_en_i), .osk_auto_i(osk_auto_i),
        .key_i(key_i), .scale_o(scale_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, advanced on every rising edge and compared shortly after
    always @(posedge clk) begin
        int step, ceil, n_asf, n_arr, n_cnt, n_ctr, exp;
        bit run, tk;
        string tag;
        if (!rst_n) begin
            m_asf = 0; m_arr = 0; m_cnt = 0; m_ctr = 0;
        end else begin
            run  = osk_en_i && osk_auto_i;
            step = 1 << (m_asf / 16384);
            ceil = m_asf % 16384;
            tk   = run && (m_cnt >= m_arr);
            n_asf = upd_i ? int'(cfg_scale_i) : m_asf;
            n_arr = upd_i ? int'(cfg_rate_i) : m_arr;
            n_cnt = (!run || tk) ? 0 : m_cnt + 1;
            n_ctr = m_ctr;
            if (!run) n_ctr = 0;
            else if (tk) begin
                if (key_i) n_ctr = (m_ctr + step >= ceil) ? ceil : m_ctr + step;
                else       n_ctr = (m_ctr <= step) ? 0 : m_ctr - step;
            end
            m_asf = n_asf; m_arr = n_arr; m_cnt = n_cnt; m_ctr = n_ctr;
        end
        #2;
        if (!osk_en_i)        begin exp = 16'h3FFF;       tag = "R3"; end
        else if (!osk_auto_i) begin exp = m_asf % 16384; tag = "R4"; end
        else begin
            exp = m_ctr;
            tag = (m_ctr == m_asf % 16384) ? "R8" : (key_i ? "R5" : "R9");
        end
        if (!done) check(tag, scale_o, exp);
    end

    task automatic step_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] s, input logic [7:0] r);
        @(negedge clk);
        cfg_scale_i = s; cfg_rate_i = r; upd_i = 1'b1;
        @(negedge clk);
        upd_i = 1'b0;
    endtask

    task automatic reenter_auto;
        @(negedge clk); osk_auto_i = 1'b0;
        @(negedge clk); osk_auto_i = 1'b1;
    endtask

    initial begin
        #1_000_000;
        $display("FAIL watchdog expired actual=running expected=finished");
        errors++;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step_n(3);
        rst_n = 1'b1;
        step_n(1);
        check("R1", scale_o, 14'h3FFF);

        // disabled: configuration and pin have no effect (R3)
        key_i = 1'b1;
        load(16'h1234, 8'd7);
        step_n(4);
        check("R3", scale_o, 14'h3FFF);

        // manual passthrough, then unstrobed write is ignored (R4, R2)
        osk_en_i = 1'b1;
        step_n(1);
        check("R4", scale_o, 14'h1234);
        cfg_scale_i = 16'hC055; cfg_rate_i = 8'd9;
        step_n(3);
        check("R2", scale_o, 14'h1234);
        load(16'hC055, 8'd0);
        check("R4", scale_o, 14'h0055);

        // auto, code 3 step 8, ceiling 100, rate 0 (R6, R5, R8, R9)
        load({2'b11, 14'd100}, 8'd0);
        key_i = 1'b1;
        osk_auto_i = 1'b1;
        step_n(1);
        check("R6", scale_o, 14'd8);
        step_n(1);
        check("R5", scale_o, 14'd16);
        step_n(20);
        check("R8", scale_o, 14'd100);
        key_i = 1'b0;
        step_n(1);
        check("R9", scale_o, 14'd92);
        step_n(20);
        check("R9", scale_o, 14'd0);

        // rate 3, code 0: update every 4 clocks from entry (R7, R10)
        load({2'b00, 14'd50}, 8'd3);
        key_i = 1'b1;
        @(negedge clk); osk_auto_i = 1'b0;
        @(negedge clk); osk_auto_i = 1'b1;
        step_n(3);
        check("R10", scale_o, 14'd0);
        step_n(1);
        check("R7", scale_o, 14'd1);
        step_n(3);
        check("R7", scale_o, 14'd1);
        step_n(1);
        check("R7", scale_o, 14'd2);

        // remaining step codes (R6)
        load({2'b01, 14'd50}, 8'd0);
        reenter_auto();
        step_n(1);
        check("R6", scale_o, 14'd2);
        load({2'b10, 14'd50}, 8'd0);
        reenter_auto();
        step_n(1);
        check("R6", scale_o, 14'd4);

        // ceiling lowered below a running counter (R8)
        step_n(20);
        load({2'b10, 14'd10}, 8'd0);
        step_n(1);
        check("R8", scale_o, 14'd10);

        // random phase, the per-cycle model does the checking
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            key_i = ($urandom % 4) != 0 ? key_i : ~key_i;
            upd_i = ($urandom % 25) == 0;
            cfg_scale_i = {2'($urandom), 14'($urandom % 120)};
            cfg_rate_i = 8'($urandom % 6);
            if (($urandom % 60) == 0) osk_en_i = ~osk_en_i;
            if (($urandom % 50) == 0) osk_auto_i = ~osk_auto_i;
        end
        step_n(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule